// File: doc/BRIEF.md
# Command-Controlled Down-Counting Interval Timer

This block is a 14-bit binary down-counter that measures intervals in periods of a separate timer clock. The host writes the interval length as two bytes. The low byte holds count bits 7..0. The high byte holds count bits 13..8 in its bits 5..0, and its bit 6 selects the output waveform. A two-bit command then starts the counter, stops it, or changes what happens at the end of the current interval. Each time the counter finishes an interval, it raises a one-cycle terminal-count pulse, reloads itself and keeps running. It stops at that point only if a stop has been requested.

The timer clock is asynchronous to the host clock. It passes through a two-stage synchronizer, and each rising edge becomes a single-cycle count step. The output pin idles high. It can either produce a square wave whose period is the programmed interval, or drop low for only the last step of each interval.

Top module: `tmr14_top`

## Requirements
- R1: While reset is asserted and after it is released, `tmr_out_o` is 1, `tc_o` is 0 and the counter is idle; both length bytes reset to zero.
- R2: Command code 2'b11 given while idle starts a run of N steps. `tc_o` pulses high for exactly one clock when the N-th step completes, and again after every further N steps, because the counter reloads automatically.
- R3: Command code 2'b00 has no effect: it neither starts an idle counter nor disturbs a running one.
- R4: Command code 2'b01 given while running stops the counter at once. No further `tc_o` pulse occurs and `tmr_out_o` returns high.
- R5: Command code 2'b10 given while running lets the current interval finish. The counter gives that interval's `tc_o` pulse, then stops, and no pulses follow.
- R6: Command codes 2'b01 and 2'b10 given while idle have no effect. A later start behaves normally and is not stopped early.
- R7: Command code 2'b11 given while running leaves the current interval unchanged. The length programmed at that moment is used from the next terminal count onward.
- R8: With waveform bit (high byte bit 6) = 1, an interval of N steps keeps `tmr_out_o` high for ceil(N/2) steps and then low for floor(N/2) steps, so an odd N gives the extra step to the high half.
- R9: With waveform bit = 0, `tmr_out_o` is low only during the final step of each interval and high otherwise.
- R10: A programmed length of 0 or 1 behaves as a length of 2.
- R11: The length is {high byte bits 5..0, low byte bits 7..0}. Writing the length registers during a run does not change the interval until the next start or the next command-2'b11 reload.
- R12: One rising edge of `tmr_clk_i` advances the counter by exactly one step, however long the timer clock stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock; all state is clocked on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tmr_clk_i | input | 1 | Asynchronous timer clock; each rising edge is one count step |
| wr_data_i | input | 8 | Data byte for the length registers |
| len_lo_we_i | input | 1 | Write strobe for the low length byte |
| len_hi_we_i | input | 1 | Write strobe for the high length byte (bits 5..0 count, bit 6 waveform) |
| cmd_vld_i | input | 1 | One-cycle strobe qualifying `cmd_i` |
| cmd_i | input | 2 | Command: 00 none, 01 stop now, 10 stop at terminal count, 11 start / reload |
| tmr_out_o | output | 1 | Timer output pin (square wave or end-of-interval low pulse) |
| tc_o | output | 1 | One-cycle terminal-count pulse |

## Verification
The assertions assume that a timer-clock edge never turns into count steps on two consecutive host cycles. For that to hold, each high and low phase of the timer clock must last longer than one host cycle. The stimulus holds every timer-clock phase for at least three host clocks, and it issues commands and register writes on host-clock phases between steps. This keeps the cycle in which each step, command and terminal count lands unambiguous. Command strobes are single-cycle and never overlap a length write in a way that matters to the checked outcome.

// File: rtl/tmr14_pkg.sv
package tmr14_pkg;

  typedef enum logic [1:0] {
    CMD_NOP     = 2'b00,
    CMD_HALT    = 2'b01,
    CMD_HALT_TC = 2'b10,
    CMD_GO      = 2'b11
  } tmr_cmd_e;

  typedef enum logic {
    WAVE_PULSE  = 1'b0,
    WAVE_SQUARE = 1'b1
  } tmr_wave_e;

endpackage

// File: rtl/tmr14_tick_sync.sv
module tmr14_tick_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic tick_o
);
  localparam int unsigned CHAIN_W = SYNC_STAGES + 1;

  logic [CHAIN_W-1:0] chain_q;
  logic [CHAIN_W-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[CHAIN_W-2:0], async_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  // Rising edge seen at the synchronizer output, one cycle wide.
  assign tick_o = chain_q[CHAIN_W-2] & ~chain_q[CHAIN_W-1];

endmodule

// File: rtl/tmr14_len_regs.sv
module tmr14_len_regs
  import tmr14_pkg::*;
#(
  parameter int unsigned CNT_W  = 14,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              lo_we_i,
  input  logic              hi_we_i,
  output logic [CNT_W-1:0]  prog_len_o,
  output tmr_wave_e         prog_wave_o
);
  localparam int unsigned HI_W = CNT_W - BYTE_W;
  localparam logic [CNT_W-1:0] MIN_LEN = CNT_W'(2);

  logic [BYTE_W-1:0] lo_q, lo_d;
  logic [BYTE_W-1:0] hi_q, hi_d;
  logic [CNT_W-1:0]  raw_len;

  always_comb begin
    lo_d = lo_q;
    hi_d = hi_q;
    if (lo_we_i) lo_d = wr_data_i;
    if (hi_we_i) hi_d = wr_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  always_comb begin
    raw_len     = {hi_q[HI_W-1:0], lo_q};
    prog_len_o  = (raw_len < MIN_LEN) ? MIN_LEN : raw_len;
    prog_wave_o = tmr_wave_e'(hi_q[HI_W]);
  end

endmodule

// File: rtl/tmr14_ctrl.sv
module tmr14_ctrl
  import tmr14_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_vld_i,
  input  logic [1:0] cmd_i,
  input  logic       term_i,
  output logic       run_o,
  output logic       kill_o,
  output logic       load_o
);
  logic run_q, run_d;
  logic stop_pend_q, stop_pend_d;
  logic rel_pend_q, rel_pend_d;
  logic is_halt, is_halt_tc, is_go;
  logic eff_stop, eff_rel;

  assign is_halt    = cmd_vld_i && (tmr_cmd_e'(cmd_i) == CMD_HALT);
  assign is_halt_tc = cmd_vld_i && (tmr_cmd_e'(cmd_i) == CMD_HALT_TC);
  assign is_go      = cmd_vld_i && (tmr_cmd_e'(cmd_i) == CMD_GO);

  // Stop-at-once suppresses the step of this cycle.
  assign kill_o = run_q & is_halt;

  always_comb begin
    run_d       = run_q;
    stop_pend_d = stop_pend_q;
    rel_pend_d  = rel_pend_q;
    load_o      = 1'b0;
    eff_stop    = (stop_pend_q & ~is_go) | is_halt_tc;
    eff_rel     = rel_pend_q | is_go;
    if (!run_q) begin
      stop_pend_d = 1'b0;
      rel_pend_d  = 1'b0;
      if (is_go) begin
        run_d  = 1'b1;
        load_o = 1'b1;
      end
    end else if (is_halt) begin
      run_d       = 1'b0;
      stop_pend_d = 1'b0;
      rel_pend_d  = 1'b0;
    end else if (term_i) begin
      run_d       = ~eff_stop;
      load_o      = eff_rel;
      stop_pend_d = 1'b0;
      rel_pend_d  = 1'b0;
    end else begin
      stop_pend_d = eff_stop;
      rel_pend_d  = eff_rel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q       <= 1'b0;
      stop_pend_q <= 1'b0;
      rel_pend_q  <= 1'b0;
    end else begin
      run_q       <= run_d;
      stop_pend_q <= stop_pend_d;
      rel_pend_q  <= rel_pend_d;
    end
  end

  assign run_o = run_q;

endmodule

// File: rtl/tmr14_core.sv
module tmr14_core
  import tmr14_pkg::*;
#(
  parameter int unsigned CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             kill_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] prog_len_i,
  input  tmr_wave_e        prog_wave_i,
  output logic             term_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] act_len_o,
  output logic             out_o,
  output logic             tc_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] act_q, act_d;
  tmr_wave_e        wave_q, wave_d;
  logic             out_q, out_d;
  logic             tc_q;
  logic             step;
  logic [CNT_W-1:0] fall_at;

  assign step   = run_i & tick_i & ~kill_i;
  assign term_o = step && (cnt_q == ONE);

  // Count value whose step takes the output low.
  assign fall_at = (wave_q == WAVE_SQUARE) ? ((act_q >> 1) + ONE) : TWO;

  always_comb begin
    cnt_d  = cnt_q;
    act_d  = act_q;
    wave_d = wave_q;
    out_d  = out_q;
    if (term_o) begin
      out_d = 1'b1;
      if (load_i) begin
        cnt_d  = prog_len_i;
        act_d  = prog_len_i;
        wave_d = prog_wave_i;
      end else begin
        cnt_d = act_q;
      end
    end else if (load_i) begin
      cnt_d  = prog_len_i;
      act_d  = prog_len_i;
      wave_d = prog_wave_i;
      out_d  = 1'b1;
    end else if (kill_i) begin
      out_d = 1'b1;
    end else if (step) begin
      cnt_d = cnt_q - ONE;
      if (cnt_q == fall_at) out_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= TWO;
      act_q  <= TWO;
      wave_q <= WAVE_PULSE;
      out_q  <= 1'b1;
      tc_q   <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      act_q  <= act_d;
      wave_q <= wave_d;
      out_q  <= out_d;
      tc_q   <= term_o;
    end
  end

  assign cnt_o     = cnt_q;
  assign act_len_o = act_q;
  assign out_o     = out_q;
  assign tc_o      = tc_q;

endmodule

// File: rtl/tmr14_top.sv
module tmr14_top
  import tmr14_pkg::*;
#(
  parameter int unsigned CNT_W       = 14,
  parameter int unsigned BYTE_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tmr_clk_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              len_lo_we_i,
  input  logic              len_hi_we_i,
  input  logic              cmd_vld_i,
  input  logic [1:0]        cmd_i,
  output logic              tmr_out_o,
  output logic              tc_o
);
  logic [1:0]       rst_pipe_q;
  logic             rst_sync_n;
  logic             tick;
  logic             run_q;
  logic             kill;
  logic             load;
  logic             term;
  logic [CNT_W-1:0] prog_len;
  tmr_wave_e        prog_wave;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] act_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[1];

  tmr14_tick_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .async_i (tmr_clk_i),
    .tick_o  (tick)
  );

  tmr14_len_regs #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_len (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .wr_data_i   (wr_data_i),
    .lo_we_i     (len_lo_we_i),
    .hi_we_i     (len_hi_we_i),
    .prog_len_o  (prog_len),
    .prog_wave_o (prog_wave)
  );

  tmr14_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cmd_vld_i (cmd_vld_i),
    .cmd_i     (cmd_i),
    .term_i    (term),
    .run_o     (run_q),
    .kill_o    (kill),
    .load_o    (load)
  );

  tmr14_core #(.CNT_W(CNT_W)) u_core (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .tick_i      (tick),
    .run_i       (run_q),
    .kill_i      (kill),
    .load_i      (load),
    .prog_len_i  (prog_len),
    .prog_wave_i (prog_wave),
    .term_o      (term),
    .cnt_o       (cnt_q),
    .act_len_o   (act_len),
    .out_o       (tmr_out_o),
    .tc_o        (tc_o)
  );

endmodule

// File: rtl/tmr14_chk.sv
module tmr14_chk #(
  parameter int unsigned CNT_W = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_vld,
  input logic [1:0]       cmd,
  input logic             tick,
  input logic             running,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] act_len,
  input logic             out_o,
  input logic             tc_o
);
  // R2: terminal-count pulse is one clock wide
  p_tc_onecycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tc_o |=> !tc_o);

  // R2: start command on an idle counter makes it run
  p_go_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && cmd == 2'b11 && !running) |=> running);

  // R4: stop-now command is never followed by a terminal count
  p_halt_no_tc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && cmd == 2'b01) |=> (!tc_o && !running));

  // R1/R4: an idle counter holds the pin high
  p_idle_out_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> out_o);

  // R10: running count stays within 1..length and length is at least 2
  p_cnt_bounds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (cnt != '0 && cnt <= act_len && act_len >= CNT_W'(2)));

  // R12: one timer edge yields a single-cycle step
  p_tick_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

bind tmr14_top tmr14_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .cmd_vld (cmd_vld_i),
  .cmd     (cmd_i),
  .tick    (tick),
  .running (run_q),
  .cnt     (cnt_q),
  .act_len (act_len),
  .out_o   (tmr_out_o),
  .tc_o    (tc_o)
);

// File: tb/sim_tmr14_top.sv
`timescale 1ns/1ps
module sim_tmr14_top;
  logic       clk;
  logic       rst_n;
  logic       tmr_clk;
  logic [7:0] wr_data;
  logic       lo_we;
  logic       hi_we;
  logic       cmd_vld;
  logic [1:0] cmd;
  logic       tmr_out;
  logic       tc;

  int n_checks = 0;
  int n_fail   = 0;
  int tc_seen  = 0;
  int tc_wide  = 0;
  bit tc_prev  = 1'b0;
  bit done     = 1'b0;

  tmr14_top u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .tmr_clk_i   (tmr_clk),
    .wr_data_i   (wr_data),
    .len_lo_we_i (lo_we),
    .len_hi_we_i (hi_we),
    .cmd_vld_i   (cmd_vld),
    .cmd_i       (cmd),
    .tmr_out_o   (tmr_out),
    .tc_o        (tc)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(negedge clk) begin
    if (rst_n) begin
      if (tc) tc_seen++;
      if (tc && tc_prev) tc_wide++;
      tc_prev <= tc;
    end else begin
      tc_prev <= 1'b0;
    end
  end

  task automatic chk_eq(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tmr_clk = 1'b0; wr_data = '0;
    lo_we = 1'b0; hi_we = 1'b0; cmd_vld = 1'b0; cmd = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr_len(input logic [7:0] hi, input logic [7:0] lo);
    wr_data = lo; lo_we = 1'b1;
    @(negedge clk);
    lo_we = 1'b0; wr_data = hi; hi_we = 1'b1;
    @(negedge clk);
    hi_we = 1'b0;
  endtask

  task automatic send_cmd(input logic [1:0] c);
    cmd = c; cmd_vld = 1'b1;
    @(negedge clk);
    cmd_vld = 1'b0; cmd = 2'b00;
    @(negedge clk);
  endtask

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) begin
      tmr_clk = 1'b1;
      repeat (3) @(negedge clk);
      tmr_clk = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk_eq("R1 out in reset", tmr_out, 1);
    chk_eq("R1 tc in reset", tc, 0);
    do_reset();
    chk_eq("R1 out after reset", tmr_out, 1);
    begin
      int b = tc_seen;
      tick_n(4);
      chk_eq("R1 idle after reset, no tc", tc_seen - b, 0);
    end
  endtask

  task automatic t_start_period();
    int b;
    do_reset();
    wr_len(8'h00, 8'h05);
    send_cmd(2'b11);
    b = tc_seen;
    tick_n(4);
    chk_eq("R2 no tc before step N", tc_seen - b, 0);
    tick_n(1);
    chk_eq("R2 tc at step N", tc_seen - b, 1);
    tick_n(10);
    chk_eq("R2 auto reload period", tc_seen - b, 3);
    chk_eq("R2 tc one clock wide", tc_wide, 0);
  endtask

  task automatic t_nop();
    int b;
    do_reset();
    wr_len(8'h00, 8'h03);
    send_cmd(2'b00);
    b = tc_seen;
    tick_n(6);
    chk_eq("R3 nop does not start", tc_seen - b, 0);
    send_cmd(2'b11);
    tick_n(1);
    send_cmd(2'b00);
    tick_n(5);
    chk_eq("R3 nop keeps run", tc_seen - b, 2);
  endtask

  task automatic t_halt_now();
    int b;
    do_reset();
    wr_len(8'h40, 8'h06);
    send_cmd(2'b11);
    b = tc_seen;
    tick_n(4);
    chk_eq("R4 square low before halt", tmr_out, 0);
    send_cmd(2'b01);
    chk_eq("R4 out high after halt", tmr_out, 1);
    tick_n(12);
    chk_eq("R4 no tc after halt", tc_seen - b, 0);
    chk_eq("R4 out stays high", tmr_out, 1);
  endtask

  task automatic t_halt_tc();
    int b;
    do_reset();
    wr_len(8'h00, 8'h04);
    send_cmd(2'b11);
    b = tc_seen;
    tick_n(2);
    send_cmd(2'b10);
    tick_n(1);
    chk_eq("R5 count continues", tc_seen - b, 0);
    tick_n(1);
    chk_eq("R5 finishing tc", tc_seen - b, 1);
    tick_n(9);
    chk_eq("R5 stopped after tc", tc_seen - b, 1);
    chk_eq("R5 out high when stopped", tmr_out, 1);
  endtask

  task automatic t_idle_stops();
    int b;
    do_reset();
    wr_len(8'h00, 8'h03);
    send_cmd(2'b01);
    send_cmd(2'b10);
    b = tc_seen;
    tick_n(5);
    chk_eq("R6 idle stop cmds do not start", tc_seen - b, 0);
    send_cmd(2'b11);
    tick_n(6);
    chk_eq("R6 later start runs on", tc_seen - b, 2);
  endtask

  task automatic t_reload();
    int b;
    do_reset();
    wr_len(8'h00, 8'h04);
    send_cmd(2'b11);
    b = tc_seen;
    tick_n(1);
    wr_len(8'h00, 8'h06);
    tick_n(3);
    chk_eq("R11 write during run keeps length", tc_seen - b, 1);
    tick_n(4);
    chk_eq("R11 old length still used", tc_seen - b, 2);
    tick_n(1);
    send_cmd(2'b11);
    tick_n(3);
    chk_eq("R7 current interval unchanged", tc_seen - b, 3);
    tick_n(5);
    chk_eq("R7 new length not yet done", tc_seen - b, 3);
    tick_n(1);
    chk_eq("R7 new length after reload", tc_seen - b, 4);
  endtask

  task automatic t_wave(input logic [7:0] hi, input logic [7:0] lo,
                        input int n, input int exp_hi, input string tag);
    int hcnt = 0;
    int lcnt = 0;
    do_reset();
    wr_len(hi, lo);
    send_cmd(2'b11);
    tick_n(n);
    for (int i = 0; i < n; i++) begin
      tick_n(1);
      if (tmr_out) hcnt++; else lcnt++;
    end
    chk_eq({tag, " high steps"}, hcnt, exp_hi);
    chk_eq({tag, " low steps"}, lcnt, n - exp_hi);
  endtask

  task automatic t_clamp(input logic [7:0] lo);
    int b;
    do_reset();
    wr_len(8'h00, lo);
    send_cmd(2'b11);
    b = tc_seen;
    tick_n(1);
    chk_eq("R10 no tc after one step", tc_seen - b, 0);
    tick_n(1);
    chk_eq("R10 short length acts as 2", tc_seen - b, 1);
  endtask

  task automatic t_fields();
    int b;
    do_reset();
    wr_len(8'h01, 8'h05);
    send_cmd(2'b11);
    b = tc_seen;
    tick_n(260);
    chk_eq("R11 261 not done at 260", tc_seen - b, 0);
    tick_n(1);
    chk_eq("R11 hi/lo field merge", tc_seen - b, 1);
  endtask

  task automatic t_long_high();
    int b;
    do_reset();
    wr_len(8'h00, 8'h02);
    send_cmd(2'b11);
    b = tc_seen;
    tmr_clk = 1'b1;
    repeat (30) @(negedge clk);
    tmr_clk = 1'b0;
    repeat (3) @(negedge clk);
    chk_eq("R12 long high is one step", tc_seen - b, 0);
    tick_n(1);
    chk_eq("R12 second edge completes", tc_seen - b, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tmr_clk = 1'b0; wr_data = '0;
    lo_we = 1'b0; hi_we = 1'b0; cmd_vld = 1'b0; cmd = 2'b00;
    t_reset();
    t_start_period();
    t_nop();
    t_halt_now();
    t_halt_tc();
    t_idle_stops();
    t_reload();
    t_wave(8'h40, 8'h05, 5, 3, "R8 square odd");
    t_wave(8'h40, 8'h04, 4, 2, "R8 square even");
    t_wave(8'h00, 8'h04, 4, 3, "R9 pulse mode");
    t_clamp(8'h00);
    t_clamp(8'h01);
    t_fields();
    t_long_high();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule